// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a one-bit-wide synchronous RAM that can misbehave on purpose. A run-time configuration selects one functional fault out of a fixed catalogue. The fault involves a victim cell and, for most kinds, an aggressor cell. Every read and write then follows the faulty behaviour instead of plain storage. The block stands in for a real memory array when a march-style built-in self-test controller is verified: the controller must flag every configured fault, and it must stay silent when fault injection is switched off.

The catalogue has stuck cells and blocked transitions. It has three kinds of coupling, where a write transition, any access, or a held state of the aggressor disturbs the victim. It has wired-AND and wired-OR bridges and three address-decoder defects. It also has a cell that forgets its content after a programmed number of cycles without a write. Read data is registered and appears one cycle after the read. The configuration may change only while no access is made, and the bench applies a reset after each change.

Top module: `fault_ram`

## Requirements
- R1: After reset every cell reads 0. With `flt_en`=0, whatever `flt_kind` holds, a read returns the value last written to that address. `rdata` changes only on a read (`cs`=1, `we`=0) and shows the value in the cycle after the read.
- R2: Kind 1 (stuck): the victim cell always reads `flt_vval`, and writes to it have no effect.
- R3: Kind 2 (transition): a write that would move the victim away from `flt_vval` is dropped. A write toward `flt_vval`, or one that leaves the value unchanged, works normally.
- R4: Kind 3 (inversion coupling): a write that changes the aggressor to `flt_atrig` (from its complement) inverts the victim.
- R5: Kind 4 (idempotent coupling): a write that changes the aggressor to `flt_atrig` sets the victim to `flt_vval`.
- R6: Kind 5 (dynamic coupling): any access to the aggressor whose data equals `flt_atrig` sets the victim to `flt_vval`. For a write the data is the written value; for a read it is the stored value.
- R7: Kind 6 (state coupling): whenever the aggressor holds `flt_atrig`, the victim holds and reads `flt_vval`.
- R8: Kinds 7 and 8 (bridge): victim and aggressor both hold the AND (kind 7) or the OR (kind 8) of their two values after every cycle.
- R9: Kind 9: address `flt_victim` reaches no cell. Writes to it are lost and reads of it return 0.
- R10: Kind 10: address `flt_victim` reaches cell `flt_aggr` for both reads and writes. Cell `flt_victim` can no longer be reached.
- R11: Kind 11: address `flt_victim` reaches cells `flt_victim` and `flt_aggr` together. A write stores into both, and a read returns the AND of the two.
- R12: Kind 12 (retention): when the victim has gone `flt_hold`+1 clock edges without a write (counting from its last write or from reset), it takes `flt_vval`. A read in any earlier cycle returns the written value.
- R13: A cycle with `cs`=0 changes no cell, whatever `we`, `addr` and `wdata` are, and leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all cells and `rdata` |
| cs | input | 1 | Access strobe for this cycle |
| we | input | 1 | 1 = write, 0 = read (when `cs`=1) |
| addr | input | AW | Access address |
| wdata | input | 1 | Write data |
| rdata | output | 1 | Registered read data |
| flt_en | input | 1 | 1 = the configured fault is active |
| flt_kind | input | 4 | Fault kind, encoding as in R2 to R12 |
| flt_victim | input | AW | Victim cell / faulty address |
| flt_aggr | input | AW | Aggressor cell / alias target |
| flt_atrig | input | 1 | Aggressor value that triggers the fault |
| flt_vval | input | 1 | Value forced into, or kept by, the victim |
| flt_hold | input | HW | Retention idle limit in cycles |

## Verification
The bench builds the block with AW=4 (16 cells) and HW=5. With so few cells, random traffic, half of it aimed at the victim and aggressor, meets every trigger condition of the coupling, bridging and decoder kinds many times in each run. Retention limits are drawn from 2 to 7 cycles, so a cell can decay between random writes and also in a directed idle stretch, where the exact cycle of the loss is checked.

// File: rtl/fram_pkg.sv
package fram_pkg;
  typedef enum logic [3:0] {
    FK_NONE     = 4'd0,
    FK_STUCK    = 4'd1,
    FK_TRANS    = 4'd2,
    FK_CF_INV   = 4'd3,
    FK_CF_IDEM  = 4'd4,
    FK_CF_DYN   = 4'd5,
    FK_STATE    = 4'd6,
    FK_BR_AND   = 4'd7,
    FK_BR_OR    = 4'd8,
    FK_AD_NONE  = 4'd9,
    FK_AD_ALIAS = 4'd10,
    FK_AD_MULTI = 4'd11,
    FK_RETAIN   = 4'd12
  } fault_kind_e;
endpackage

// File: rtl/fram_decode.sv
module fram_decode
  import fram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          act,
  input  fault_kind_e   kind,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] victim,
  input  logic [AW-1:0] aggr,
  output logic [AW-1:0] p_idx,
  output logic          p_hit,
  output logic [AW-1:0] s_idx,
  output logic          s_hit
);
  always_comb begin
    p_idx = addr;
    p_hit = 1'b1;
    s_idx = aggr;
    s_hit = 1'b0;
    if (act && addr == victim) begin
      case (kind)
        FK_AD_NONE:  p_hit = 1'b0;
        FK_AD_ALIAS: p_idx = aggr;
        FK_AD_MULTI: s_hit = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fram_retain.sv
module fram_retain #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vic_wr,
  input  logic [HW-1:0] hold,
  output logic          decay
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || vic_wr) cnt_q <= '0;
    else if (cnt_q < hold) cnt_q <= cnt_q + 1'b1;
  end

  assign decay = (cnt_q >= hold);

  // R12
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!vic_wr && cnt_q < hold) |=> cnt_q == HW'($past(cnt_q) + 1'b1));

  // R12
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    vic_wr |=> cnt_q == '0);
endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fram_pkg::*;
#(
  parameter int AW = 6,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wdata,
  output logic          rdata,
  input  logic          flt_en,
  input  logic [3:0]    flt_kind,
  input  logic [AW-1:0] flt_victim,
  input  logic [AW-1:0] flt_aggr,
  input  logic          flt_atrig,
  input  logic          flt_vval,
  input  logic [HW-1:0] flt_hold
);
  localparam int DEPTH = 1 << AW;

  fault_kind_e kind;
  assign kind = fault_kind_e'(flt_kind);

  logic [DEPTH-1:0] mem_q, mem_d, view;
  logic [AW-1:0]    p_idx, s_idx;
  logic             p_hit, s_hit, rd_val, vic_wr, decay, wr;

  fram_decode #(.AW(AW)) u_dec (
    .act(flt_en), .kind(kind), .addr(addr), .victim(flt_victim),
    .aggr(flt_aggr), .p_idx(p_idx), .p_hit(p_hit), .s_idx(s_idx), .s_hit(s_hit)
  );

  assign wr     = cs && we;
  assign vic_wr = wr && ((p_hit && p_idx == flt_victim) || (s_hit && s_idx == flt_victim));

  fram_retain #(.HW(HW)) u_ret (
    .clk(clk), .rst(rst), .vic_wr(vic_wr), .hold(flt_hold), .decay(decay)
  );

  // static forcing: stuck, state coupling, bridges
  function automatic logic [DEPTH-1:0] settle(input logic [DEPTH-1:0] m);
    logic [DEPTH-1:0] r;
    logic b;
    r = m;
    if (flt_en) begin
      case (kind)
        FK_STUCK: r[flt_victim] = flt_vval;
        FK_STATE: if (m[flt_aggr] == flt_atrig) r[flt_victim] = flt_vval;
        FK_BR_AND: begin
          b = m[flt_victim] & m[flt_aggr];
          r[flt_victim] = b;
          r[flt_aggr]   = b;
        end
        FK_BR_OR: begin
          b = m[flt_victim] | m[flt_aggr];
          r[flt_victim] = b;
          r[flt_aggr]   = b;
        end
        default: ;
      endcase
    end
    return r;
  endfunction

  // one cell write with transition and write-coupling effects
  function automatic logic [DEPTH-1:0] put(input logic [DEPTH-1:0] m,
                                           input logic [AW-1:0] c,
                                           input logic old, input logic d);
    logic [DEPTH-1:0] r;
    r = m;
    if (!(flt_en && kind == FK_TRANS && c == flt_victim && old == flt_vval && d != flt_vval))
      r[c] = d;
    if (flt_en && c == flt_aggr && old != d && d == flt_atrig) begin
      if (kind == FK_CF_INV)       r[flt_victim] = ~r[flt_victim];
      else if (kind == FK_CF_IDEM) r[flt_victim] = flt_vval;
    end
    return r;
  endfunction

  always_comb begin
    view = settle(mem_q);
    if (p_hit && s_hit) rd_val = view[p_idx] & view[s_idx];
    else if (p_hit)     rd_val = view[p_idx];
    else                rd_val = 1'b0;

    mem_d = view;
    if (flt_en && kind == FK_RETAIN && decay) mem_d[flt_victim] = flt_vval;
    if (wr && p_hit) mem_d = put(mem_d, p_idx, view[p_idx], wdata);
    if (wr && s_hit) mem_d = put(mem_d, s_idx, view[s_idx], wdata);
    if (flt_en && kind == FK_CF_DYN && cs && p_hit && p_idx == flt_aggr &&
        (we ? wdata : view[flt_aggr]) == flt_atrig)
      mem_d[flt_victim] = flt_vval;
    mem_d = settle(mem_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
      rdata <= 1'b0;
    end else begin
      mem_q <= mem_d;
      if (cs && !we) rdata <= rd_val;
    end
  end

  // R1
  plain_decode_chk: assert property (@(posedge clk) disable iff (rst)
    !flt_en |-> (p_hit && !s_hit && p_idx == addr));

  // R2
  stuck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_en && kind == FK_STUCK) |=> mem_q[$past(flt_victim)] == $past(flt_vval));

  // R8
  bridge_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_en && (kind == FK_BR_AND || kind == FK_BR_OR))
      |=> mem_q[$past(flt_victim)] == mem_q[$past(flt_aggr)]);

  // R9
  nocell_read_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_en && kind == FK_AD_NONE && cs && !we && addr == flt_victim) |=> rdata == 1'b0);

  // R13
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(rdata));
endmodule

// File: tb/sim_fault_ram.sv
`timescale 1ns/1ps
module sim_fault_ram;
  localparam int AW = 4;
  localparam int HW = 5;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, we = 1'b0, wdata = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rdata;
  logic flt_en = 1'b0;
  logic [3:0] flt_kind = '0;
  logic [AW-1:0] flt_victim = '0, flt_aggr = '0;
  logic flt_atrig = 1'b0, flt_vval = 1'b0;
  logic [HW-1:0] flt_hold = '0;

  int tests = 0;
  int fails = 0;

  logic [D-1:0] mref;
  int mcnt;
  logic last_rd;

  always #4 clk = ~clk;

  fault_ram #(.AW(AW), .HW(HW)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .flt_en(flt_en), .flt_kind(flt_kind), .flt_victim(flt_victim),
    .flt_aggr(flt_aggr), .flt_atrig(flt_atrig), .flt_vval(flt_vval), .flt_hold(flt_hold)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic string tag_of();
    int k = int'(flt_kind);
    if (!flt_en || k == 0) return "R1";
    if (k <= 6) return $sformatf("R%0d", k + 1);
    if (k <= 8) return "R8";
    return $sformatf("R%0d", k);
  endfunction

  // reference: static forcing (R2 stuck, R7 state, R8 bridges)
  function automatic logic [D-1:0] m_settle(input logic [D-1:0] m);
    logic [D-1:0] r = m;
    logic b;
    if (flt_en) begin
      if (flt_kind == 4'd1) r[flt_victim] = flt_vval;
      if (flt_kind == 4'd6 && m[flt_aggr] == flt_atrig) r[flt_victim] = flt_vval;
      if (flt_kind == 4'd7 || flt_kind == 4'd8) begin
        b = (flt_kind == 4'd7) ? (m[flt_victim] & m[flt_aggr]) : (m[flt_victim] | m[flt_aggr]);
        r[flt_victim] = b;
        r[flt_aggr] = b;
      end
    end
    return r;
  endfunction

  // reference: a cell write (R3 transition, R4/R5 write coupling)
  function automatic logic [D-1:0] m_put(input logic [D-1:0] n, input logic [D-1:0] v,
                                         input int c, input logic d);
    logic [D-1:0] r = n;
    bit blocked = flt_en && flt_kind == 4'd2 && c == int'(flt_victim) &&
                  v[c] == flt_vval && d != flt_vval;
    if (!blocked) r[c] = d;
    if (flt_en && c == int'(flt_aggr) && v[c] != d && d == flt_atrig) begin
      if (flt_kind == 4'd3) r[flt_victim] = ~r[flt_victim];
      if (flt_kind == 4'd4) r[flt_victim] = flt_vval;
    end
    return r;
  endfunction

  // one clock of stimulus with reference prediction and read check
  task automatic cyc(input logic c, input logic w, input logic [AW-1:0] a, input logic d,
                     output logic got);
    logic [D-1:0] v, n;
    bit ph = 1, sh = 0, vw;
    int pi = int'(a), si = int'(flt_aggr);
    logic rv;
    v = m_settle(mref);
    if (flt_en && a == flt_victim) begin
      if (flt_kind == 4'd9)  ph = 0;            // R9
      if (flt_kind == 4'd10) pi = int'(flt_aggr); // R10
      if (flt_kind == 4'd11) sh = 1;            // R11
    end
    rv = !ph ? 1'b0 : (sh ? (v[pi] & v[si]) : v[pi]);
    n = v;
    if (flt_en && flt_kind == 4'd12 && mcnt >= int'(flt_hold)) n[flt_victim] = flt_vval; // R12
    if (c && w) begin
      if (ph) n = m_put(n, v, pi, d);
      if (sh) n = m_put(n, v, si, d);
    end
    if (flt_en && flt_kind == 4'd5 && c && ph && pi == int'(flt_aggr) &&
        (w ? d : v[flt_aggr]) == flt_atrig) n[flt_victim] = flt_vval; // R6
    n = m_settle(n);
    vw = c && w && ((ph && pi == int'(flt_victim)) || (sh && si == int'(flt_victim)));
    if (vw) mcnt = 0;
    else if (mcnt < int'(flt_hold)) mcnt++;
    mref = n;
    if (c && !w) last_rd = rv;   // R13: rdata only moves on reads
    cs = c; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    got = rdata;
    chk(rdata, last_rd, tag_of());
  endtask

  task automatic setup(input logic en, input int k, input int vi, input int ag,
                       input logic at, input logic vv, input int hd);
    flt_en = en; flt_kind = 4'(k); flt_victim = AW'(vi); flt_aggr = AW'(ag);
    flt_atrig = at; flt_vval = vv; flt_hold = HW'(hd);
    cs = 0; we = 0;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    mref = '0; mcnt = 0; last_rd = 1'b0;
  endtask

  task automatic rnd_run(input int n);
    logic g;
    for (int i = 0; i < n; i++) begin
      logic c = ($urandom % 5) != 0;
      logic w = $urandom % 2;
      logic [AW-1:0] a;
      case ($urandom % 4)
        0: a = flt_victim;
        1: a = flt_aggr;
        default: a = AW'($urandom);
      endcase
      cyc(c, w, a, 1'($urandom), g);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic g;
    void'($urandom(32'd1234));
    mref = '0; mcnt = 0; last_rd = 0;

    // R1 reset state
    setup(0, 0, 0, 1, 0, 0, 2);
    chk(rdata, 1'b0, "R1");
    for (int a = 0; a < 4; a++) begin
      cyc(1, 0, AW'(a), 0, g);
      chk(g, 1'b0, "R1");
    end

    // R13 idle cycle leaves cell and rdata alone
    cyc(1, 1, 4'd3, 1, g);
    cyc(1, 0, 4'd3, 0, g);
    chk(g, 1'b1, "R13");
    cyc(0, 1, 4'd3, 0, g);
    chk(g, 1'b1, "R13");
    cyc(1, 0, 4'd7, 0, g);
    cyc(1, 0, 4'd3, 0, g);
    chk(g, 1'b1, "R13");

    // R2 directed stuck-at-1
    setup(1, 1, 5, 0, 0, 1, 2);
    cyc(1, 1, 4'd5, 0, g);
    cyc(1, 0, 4'd5, 0, g);
    chk(g, 1'b1, "R2");

    // R9 directed unreachable address
    setup(1, 9, 2, 0, 0, 0, 2);
    cyc(1, 1, 4'd2, 1, g);
    cyc(1, 0, 4'd2, 0, g);
    chk(g, 1'b0, "R9");

    // R11 directed multi-cell access
    setup(1, 11, 6, 9, 0, 0, 2);
    cyc(1, 1, 4'd9, 1, g);
    cyc(1, 0, 4'd6, 0, g);
    chk(g, 1'b0, "R11");
    cyc(1, 1, 4'd6, 1, g);
    cyc(1, 0, 4'd9, 0, g);
    chk(g, 1'b1, "R11");

    // R10 directed alias
    setup(1, 10, 4, 8, 0, 0, 2);
    cyc(1, 1, 4'd4, 1, g);
    cyc(1, 0, 4'd8, 0, g);
    chk(g, 1'b1, "R10");

    // R12 directed retention: hold 4, loss value 0
    setup(1, 12, 7, 0, 0, 0, 4);
    cyc(1, 1, 4'd7, 1, g);
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, 4'd7, 0, g);
      chk(g, 1'b1, "R12");
    end
    cyc(1, 0, 4'd7, 0, g);
    chk(g, 1'b0, "R12");

    // random traffic over every kind: R1 R3 R4 R5 R6 R7 R8 and the rest
    for (int k = 0; k <= 12; k++) begin
      for (int rep = 0; rep < 4; rep++) begin
        int vi = $urandom % D;
        int ag = (vi + 1 + ($urandom % (D - 1))) % D;
        setup(1, k, vi, ag, 1'($urandom), 1'($urandom), 2 + ($urandom % 6));
        rnd_run(250);
      end
    end
    // R1 disabled injection with a live kind
    for (int rep = 0; rep < 4; rep++) begin
      setup(0, 1 + ($urandom % 12), 3, 10, 1, 1, 2);
      rnd_run(250);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule